// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block guards a processor against both a stalled program and a runaway loop that services the timer too often. A 12-bit counter steps down once per prescaler period. The prescaler is built from a slow-clock enable pulse, and with the default ratio of 128 the counter runs at 256 Hz, which gives a longest timeout of 16 s. Software restarts the counter by writing a keyed command to the control register. The restart is only legitimate once the counter has fallen to the programmed window limit or below. A restart made earlier still reloads the counter, but it is reported as an error.

Either an underflow or an early restart counts as a watchdog event. Depending on the mode register, an event pulses a processor-only or a processor-plus-peripheral reset request, raises a level interrupt, or does both. The mode register accepts a single write after reset. Two halt inputs, one for debug and one for idle, can each freeze the counter when their enable bit in the mode register is set.

The register port is a simple synchronous read/write port. Read data appears one cycle after the read strobe.

Top module: `winwdt_top`

## Requirements
- R1: With the block running, the counter steps down by one every PRESCALE slow-clock pulses. A step taken at count 0 is an underflow: the counter reloads from WDV and status bit 0 is set.
- R2: After reset, the mode register (address 1) reads 0x3FFF2FFF. Its fields are WDV in [11:0], interrupt enable in bit 12, reset enable in bit 13, processor-only reset in bit 14, disable in bit 15, WDD in [27:16], debug-halt enable in bit 28 and idle-halt enable in bit 29.
- R3: The first write to the mode register after reset is stored, and it also reloads the counter from the new WDV. Every later mode write leaves the register unchanged.
- R4: A write to the control register (address 0) restarts the counter only when bits [31:24] hold 0xA5 and bit 0 is 1. A restart reloads the counter from WDV. A control write with any other key leaves the counter untouched.
- R5: An accepted restart while the counter is above WDD sets the error flag, status bit 1. A restart at or below WDD sets no flag.
- R6: While the disable bit is set, the counter holds its value, restarts are ignored, and no underflow or error is raised.
- R7: When reset enable is set, a watchdog event asserts proc_rst for RST_HOLD slow-clock pulses. periph_rst follows proc_rst unless processor-only is set, in which case periph_rst stays low.
- R8: irq is high exactly when the interrupt enable bit is set and at least one status flag is set.
- R9: The status register (address 2) returns the underflow flag in bit 0, the error flag in bit 1 and the current count in [27:16]. Reading it clears both flags, unless a new event arrives in the same cycle.
- R10: While dbg_halt is high with bit 28 set, or idle_halt is high with bit 29 set, the counter and its prescaler do not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle enable pulse for each slow-clock period |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 control, 1 mode, 2 status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| dbg_halt | input | 1 | Debug halt request |
| idle_halt | input | 1 | Idle halt request |
| irq | output | 1 | Watchdog interrupt, level |
| proc_rst | output | 1 | Processor reset request |
| periph_rst | output | 1 | Peripheral reset request |

## Verification
The restart command is tried at three points that the window check must tell apart. The first is straight after a reload, while the count is above WDD, which must flag an error. The second is after the count has fallen inside the window, which must be accepted silently. The third uses a wrong key, which must leave the count running down. The counter is also left to run past zero with full-system reset enabled, and it is run frozen under each halt input separately, disabled, and with a processor-only reset scope. These cases separate the outcomes of "reload", "flag", "ignore" and "hold". A behavioural model in the bench tracks every register-visible value and every output on each clock.

// File: rtl/winwdt_pkg.sv
package winwdt_pkg;
  localparam int MODE_W    = 30;
  localparam int WDV_LSB   = 0;
  localparam int WDD_LSB   = 16;
  localparam int B_IRQ_EN  = 12;
  localparam int B_RST_EN  = 13;
  localparam int B_PROC    = 14;
  localparam int B_DIS     = 15;
  localparam int B_DBG_EN  = 28;
  localparam int B_IDLE_EN = 29;
  localparam logic [MODE_W-1:0] MODE_RST = 30'h3FFF2FFF;
  localparam logic [7:0] RESTART_KEY = 8'hA5;
  localparam int B_RESTART = 0;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_MODE = 2'd1,
    A_STAT = 2'd2
  } wdt_addr_e;
endpackage

// File: rtl/winwdt_prescale.sv
module winwdt_prescale #(
  parameter int PRESCALE = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic slow_tick,
  input  logic run,
  input  logic clear,
  output logic step
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pre;

  assign step = run && slow_tick && (pre == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre <= '0;
    end else if (clear) begin
      pre <= '0;
    end else if (run && slow_tick) begin
      pre <= (pre == LAST) ? '0 : pre + 1'b1;
    end
  end
endmodule

// File: rtl/winwdt_regs.sv
module winwdt_regs
  import winwdt_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [31:0]       wdata,
  input  logic [CW-1:0]     cnt,
  input  logic              uf_evt,
  input  logic              fault_evt,
  output logic [MODE_W-1:0] mode,
  output logic              locked,
  output logic              mode_wr,
  output logic              restart_req,
  output logic              sts_uf,
  output logic              sts_err,
  output logic [31:0]       rdata,
  output logic              irq
);
  logic        clr;
  logic        uf_n;
  logic        err_n;
  logic [31:0] rd_mux;
  logic [31:0] stat_word;

  assign mode_wr     = wr_en && (addr == A_MODE) && !locked;
  assign restart_req = wr_en && (addr == A_CTRL) &&
                       (wdata[31:24] == RESTART_KEY) && wdata[B_RESTART];
  assign clr   = rd_en && (addr == A_STAT);
  assign uf_n  = uf_evt    || (sts_uf  && !clr);
  assign err_n = fault_evt || (sts_err && !clr);

  always_comb begin
    stat_word = '0;
    stat_word[16 +: CW] = cnt;
    stat_word[1] = sts_err;
    stat_word[0] = sts_uf;
  end

  always_comb begin
    case (addr)
      A_MODE:  rd_mux = {{(32-MODE_W){1'b0}}, mode};
      A_STAT:  rd_mux = stat_word;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= MODE_RST;
      locked  <= 1'b0;
      sts_uf  <= 1'b0;
      sts_err <= 1'b0;
      irq     <= 1'b0;
      rdata   <= '0;
    end else begin
      if (mode_wr) begin
        mode   <= wdata[MODE_W-1:0];
        locked <= 1'b1;
      end
      sts_uf  <= uf_n;
      sts_err <= err_n;
      irq     <= mode[B_IRQ_EN] && (uf_n || err_n);
      rdata   <= rd_en ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/winwdt_core.sv
module winwdt_core
  import winwdt_pkg::*;
#(
  parameter int CW       = 12,
  parameter int RST_HOLD = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slow_tick,
  input  logic          step,
  input  logic [CW-1:0] wdv,
  input  logic [CW-1:0] wdd,
  input  logic          dis,
  input  logic          rst_en,
  input  logic          proc_only,
  input  logic          dbg_en,
  input  logic          idle_en,
  input  logic          mode_wr,
  input  logic [CW-1:0] new_wdv,
  input  logic          restart_req,
  input  logic          dbg_halt,
  input  logic          idle_halt,
  output logic [CW-1:0] cnt,
  output logic          halted,
  output logic          run,
  output logic          restart_ok,
  output logic          uf_evt,
  output logic          fault_evt,
  output logic          proc_rst,
  output logic          periph_rst
);
  localparam int HW = $clog2(RST_HOLD + 1);
  localparam logic [CW-1:0] CNT_RST = MODE_RST[WDV_LSB +: CW];

  logic [HW-1:0] hold, hold_n;
  logic          full, full_n;

  assign halted     = (dbg_halt && dbg_en) || (idle_halt && idle_en);
  assign run        = !dis && !halted;
  assign restart_ok = restart_req && !dis;
  assign fault_evt  = restart_ok && (cnt > wdd);
  assign uf_evt     = step && (cnt == '0) && !restart_ok && !mode_wr;

  always_comb begin
    hold_n = hold;
    full_n = full;
    if ((uf_evt || fault_evt) && rst_en) begin
      hold_n = HW'(RST_HOLD);
      full_n = !proc_only;
    end else if ((hold != '0) && slow_tick) begin
      hold_n = hold - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= CNT_RST;
      hold       <= '0;
      full       <= 1'b0;
      proc_rst   <= 1'b0;
      periph_rst <= 1'b0;
    end else begin
      if (mode_wr)         cnt <= new_wdv;
      else if (restart_ok) cnt <= wdv;
      else if (step)       cnt <= (cnt == '0) ? wdv : cnt - 1'b1;
      hold       <= hold_n;
      full       <= full_n;
      proc_rst   <= (hold_n != '0);
      periph_rst <= (hold_n != '0) && full_n;
    end
  end
endmodule

// File: rtl/winwdt_top.sv
module winwdt_top
  import winwdt_pkg::*;
#(
  parameter int CW       = 12,
  parameter int PRESCALE = 128,
  parameter int RST_HOLD = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        slow_tick,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        dbg_halt,
  input  logic        idle_halt,
  output logic        irq,
  output logic        proc_rst,
  output logic        periph_rst
);
  logic [MODE_W-1:0] mode;
  logic              locked, mode_wr, restart_req, restart_ok;
  logic              sts_uf, sts_err, uf_evt, fault_evt;
  logic              run, halted, step;
  logic [CW-1:0]     cnt;

  winwdt_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt(cnt), .uf_evt(uf_evt), .fault_evt(fault_evt),
    .mode(mode), .locked(locked), .mode_wr(mode_wr),
    .restart_req(restart_req), .sts_uf(sts_uf), .sts_err(sts_err),
    .rdata(rdata), .irq(irq)
  );

  winwdt_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .run(run),
    .clear(restart_ok || mode_wr), .step(step)
  );

  winwdt_core #(.CW(CW), .RST_HOLD(RST_HOLD)) u_core (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .step(step),
    .wdv(mode[WDV_LSB +: CW]), .wdd(mode[WDD_LSB +: CW]),
    .dis(mode[B_DIS]), .rst_en(mode[B_RST_EN]), .proc_only(mode[B_PROC]),
    .dbg_en(mode[B_DBG_EN]), .idle_en(mode[B_IDLE_EN]),
    .mode_wr(mode_wr), .new_wdv(wdata[WDV_LSB +: CW]),
    .restart_req(restart_req), .dbg_halt(dbg_halt), .idle_halt(idle_halt),
    .cnt(cnt), .halted(halted), .run(run), .restart_ok(restart_ok),
    .uf_evt(uf_evt), .fault_evt(fault_evt),
    .proc_rst(proc_rst), .periph_rst(periph_rst)
  );
endmodule

// File: rtl/winwdt_checker.sv
module winwdt_checker
  import winwdt_pkg::*;
#(
  parameter int CW = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [MODE_W-1:0] mode,
  input logic              locked,
  input logic              mode_wr,
  input logic              restart_ok,
  input logic [CW-1:0]     cnt,
  input logic              sts_err,
  input logic              uf_evt,
  input logic              fault_evt,
  input logic              halted,
  input logic              proc_rst,
  input logic              periph_rst,
  input logic              irq
);
  logic [CW-1:0] wdv, wdd;
  assign wdv = mode[WDV_LSB +: CW];
  assign wdd = mode[WDD_LSB +: CW];

  p_lock_r3: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(mode));

  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    restart_ok |=> (cnt == $past(wdv)));

  p_early_r5: assert property (@(posedge clk) disable iff (rst)
    (restart_ok && (cnt > wdd)) |=> sts_err);

  p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    mode[B_DIS] |-> !(uf_evt || fault_evt));

  p_scope_r7: assert property (@(posedge clk) disable iff (rst)
    periph_rst |-> proc_rst);

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
    !mode[B_IRQ_EN] |=> !irq);

  p_freeze_r10: assert property (@(posedge clk) disable iff (rst)
    (halted && !restart_ok && !mode_wr) |=> $stable(cnt));
endmodule

bind winwdt_top winwdt_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .locked(locked), .mode_wr(mode_wr),
  .restart_ok(restart_ok), .cnt(cnt), .sts_err(sts_err), .uf_evt(uf_evt),
  .fault_evt(fault_evt), .halted(halted), .proc_rst(proc_rst),
  .periph_rst(periph_rst), .irq(irq)
);

// File: tb/winwdt_top_test.sv
module winwdt_top_test;
  localparam int PRE  = 4;
  localparam int HOLD = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1, stick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic        dbg = 1'b0, idle = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, proc_rst, periph_rst;

  winwdt_top #(.CW(12), .PRESCALE(PRE), .RST_HOLD(HOLD)) uut (
    .clk(clk), .rst(rst), .slow_tick(stick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .dbg_halt(dbg),
    .idle_halt(idle), .irq(irq), .proc_rst(proc_rst), .periph_rst(periph_rst)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) stick <= ~stick;

  // behavioural reference model
  logic [31:0] m_mode;
  int m_lock, m_cnt, m_pre, m_uf, m_err, m_hold, m_full;
  int m_irq, m_prst, m_frst;
  logic [31:0] m_rdata;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 32'h3FFF2FFF; m_lock = 0; m_cnt = 'hFFF; m_pre = 0;
      m_uf = 0; m_err = 0; m_hold = 0; m_full = 0;
      m_irq = 0; m_prst = 0; m_frst = 0; m_rdata = 0;
    end else begin
      int wdv, wdd, run, rs, mw, st, ft, ue, clr, nu, ne;
      wdv = int'(m_mode[11:0]);
      wdd = int'(m_mode[27:16]);
      run = (!m_mode[15] && !((dbg && m_mode[28]) || (idle && m_mode[29]))) ? 1 : 0;
      rs  = (wr_en && addr == 0 && wdata[31:24] == 8'hA5 && wdata[0] && !m_mode[15]) ? 1 : 0;
      mw  = (wr_en && addr == 1 && m_lock == 0) ? 1 : 0;
      st  = (run != 0 && stick && m_pre == PRE - 1) ? 1 : 0;
      ft  = (rs != 0 && m_cnt > wdd) ? 1 : 0;
      ue  = (st != 0 && m_cnt == 0 && rs == 0 && mw == 0) ? 1 : 0;
      if (rd_en) begin
        if (addr == 1) m_rdata = m_mode;
        else if (addr == 2) m_rdata = (m_cnt << 16) | (m_err << 1) | m_uf;
        else m_rdata = 0;
      end else m_rdata = 0;
      clr = (rd_en && addr == 2) ? 1 : 0;
      nu = (ue != 0 || (m_uf != 0 && clr == 0)) ? 1 : 0;
      ne = (ft != 0 || (m_err != 0 && clr == 0)) ? 1 : 0;
      m_irq = (m_mode[12] && (nu != 0 || ne != 0)) ? 1 : 0;
      m_uf = nu; m_err = ne;
      if ((ue != 0 || ft != 0) && m_mode[13]) begin
        m_hold = HOLD; m_full = m_mode[14] ? 0 : 1;
      end else if (m_hold != 0 && stick) m_hold--;
      m_prst = (m_hold != 0) ? 1 : 0;
      m_frst = (m_hold != 0 && m_full != 0) ? 1 : 0;
      if (mw != 0) m_cnt = int'(wdata[11:0]);
      else if (rs != 0) m_cnt = wdv;
      else if (st != 0) m_cnt = (m_cnt == 0) ? wdv : m_cnt - 1;
      if (mw != 0 || rs != 0) m_pre = 0;
      else if (run != 0 && stick) m_pre = (m_pre == PRE - 1) ? 0 : m_pre + 1;
      if (mw != 0) begin m_mode = wdata & 32'h3FFFFFFF; m_lock = 1; end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R9 rdata vs model", rdata, m_rdata);
      chk("R8 irq vs model", 32'(irq), 32'(m_irq));
      chk("R7 proc_rst vs model", 32'(proc_rst), 32'(m_prst));
      chk("R7 periph_rst vs model", 32'(periph_rst), 32'(m_frst));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, c1, c2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("reset proc_rst", 32'(proc_rst), 0);
    rd(1, v);
    chk("R2 mode reset value", v, 32'h3FFF2FFF);
    rd(2, v);
    chk("R2 count from reset WDV", v, 32'h0FFF0000);

    // WDV=20, WDD=8, irq+reset enabled, full scope, both halts enabled
    wr(1, 32'h30083014);
    rd(1, v);
    chk("R3 first mode write kept", v, 32'h30083014);
    wr(1, 32'h00008005);
    rd(1, v);
    chk("R3 second mode write ignored", v, 32'h30083014);

    wr(0, 32'hA5000001);  // count 20 > WDD 8
    chk("R8 irq on early restart", 32'(irq), 1);
    chk("R7 proc_rst on fault", 32'(proc_rst), 1);
    chk("R7 periph_rst full scope", 32'(periph_rst), 1);
    rd(2, v);
    chk("R5 error flag on early restart", 32'(v[1]), 1);
    chk("R8 irq low after clear", 32'(irq), 0);
    rd(2, v);
    chk("R9 error flag cleared by read", 32'(v[1:0]), 0);

    repeat (110) @(negedge clk);
    rd(2, v);
    chk("R1 counter ran down", 32'(v[27:16] < 12'd9 && v[27:16] > 12'd0), 1);
    wr(0, 32'hA5000001);
    rd(2, v);
    chk("R5 in-window restart no error", 32'(v[1]), 0);
    chk("R4 restart reloads WDV", 32'(v[27:16]), 20);
    repeat (30) @(negedge clk);
    wr(0, 32'h5A000001);
    rd(2, v);
    chk("R4 wrong key leaves count", 32'(v[27:16] < 12'd20), 1);
    chk("R4 wrong key no error", 32'(v[1]), 0);

    repeat (220) @(negedge clk);
    rd(2, v);
    chk("R1 underflow flag", 32'(v[0]), 1);

    dbg = 1'b1;
    rd(2, c1);
    repeat (40) @(negedge clk);
    rd(2, c2);
    chk("R10 debug halt freezes", 32'(c2[27:16]), 32'(c1[27:16]));
    dbg = 1'b0; idle = 1'b1;
    rd(2, c1);
    repeat (40) @(negedge clk);
    rd(2, c2);
    chk("R10 idle halt freezes", 32'(c2[27:16]), 32'(c1[27:16]));
    idle = 1'b0;
    repeat (40) @(negedge clk);
    rd(2, v);
    chk("R10 count resumes after halt", 32'(v[27:16] != c2[27:16]), 1);

    // disabled
    do_reset();
    wr(1, 32'h30088014);
    rd(2, c1);
    chk("R6 disabled count loaded", 32'(c1[27:16]), 20);
    repeat (100) @(negedge clk);
    wr(0, 32'hA5000001);
    rd(2, v);
    chk("R6 disabled count frozen", 32'(v[27:16]), 20);
    chk("R6 disabled no flags", 32'(v[1:0]), 0);
    chk("R6 disabled no reset", 32'(proc_rst), 0);

    // processor-only scope, interrupt off
    do_reset();
    wr(1, 32'h0002600A);
    wr(0, 32'hA5000001);
    chk("R7 proc_rst processor-only", 32'(proc_rst), 1);
    chk("R7 periph_rst stays low", 32'(periph_rst), 0);
    chk("R8 irq disabled", 32'(irq), 0);
    repeat (20) @(negedge clk);
    chk("R7 reset released after hold", 32'(proc_rst), 0);
    rd(2, v);
    chk("R5 error flag with irq off", 32'(v[1]), 1);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule